// File: doc/BRIEF.md
# Lane Predication Mask Controller

This block sits beside a scalar sequencer that issues work to a 64-lane vector unit. It owns the per-lane enable mask, which decides which lanes commit results. It also owns a per-lane compare register, which vector compares fill with one bit per lane. The sequencer sends one mask operation per cycle. The operations build structured divergent control flow: open a conditional region, switch to its alternative arm, close the region, record lanes that leave a loop, and step a loop back. Each operation returns a saved-mask result that the sequencer may keep or discard.

Lane sets set aside by open regions are held in an internal last-in first-out stack, so nested regions need no external storage. Lanes leaving a loop collect in a break accumulator. A loop step removes those lanes from the mask. Two live flags tell the sequencer when every lane is off, so a region can be skipped, and when a loop must run again. Opening a region on a full stack, or closing one on an empty stack, raises a one-cycle error and has no other effect.

Top module: `lane_mask_ctrl`

## Requirements
- R1: While reset is active and after it is released, the lane mask is all ones. The break accumulator, the compare register, the result, the stack depth, the loop flag and both error flags are zero.
- R2: A cycle with `cmp_we` high loads `cmp_data` into the compare register. Operations in later cycles use the loaded value.
- R3: Opcode 1 (open) sets the mask to mask AND compare. It pushes mask XOR new mask, which is the active lanes that failed the compare, and returns that value as the result.
- R4: Opcode 2 (alternate) sets the mask to (mask OR stack top) XOR mask. It replaces the stack top with the old mask and returns the old mask.
- R5: Opcode 3 (close) pops the stack top and ORs it into the mask. The result is the new mask.
- R6: `lanes_off` is high exactly when the mask is zero, and `lanes_on` is its inverse.
- R7: Opcode 4 ORs the mask into the break accumulator. Opcode 5 ORs the compare register into it. Opcode 6 ORs `src_mask` into it. The lane mask is unchanged, and the result is the new accumulator.
- R8: Opcode 7 (loop step) sets the mask to mask AND NOT accumulator, and the result is the new mask. `loop_again` pulses for one cycle when the new mask is nonzero. When the new mask is zero, the accumulator is cleared.
- R9: Opcode 1 with `DEPTH` entries already stacked pulses `err_overflow` for one cycle and changes no state.
- R10: Opcode 2 or 3 with an empty stack pulses `err_underflow` for one cycle and changes no state.
- R11: An operation with `busy` high, with `op_valid` low, or with opcode 0 or 8 to 15 changes neither the mask, the accumulator, the result nor the stack.
- R12: Saved masks come back in last-in first-out order across nesting up to `DEPTH` levels.
- R13: Every register updates on the clock edge that accepts the operation. All effects show in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented |
| busy | input | 1 | Sequencer stall; the operation is ignored |
| op_code | input | 4 | Operation code, 1 to 7 as in R3 to R8 |
| src_mask | input | 64 | Mask operand for opcode 6 |
| cmp_we | input | 1 | Write enable of the compare register |
| cmp_data | input | 64 | Per-lane compare results |
| lane_mask | output | 64 | Current lane enable mask |
| brk_mask | output | 64 | Break accumulator |
| res_mask | output | 64 | Saved-mask result of the last accepted operation |
| lanes_off | output | 1 | Mask is all zero |
| lanes_on | output | 1 | At least one lane enabled |
| loop_again | output | 1 | Last loop step left lanes active |
| err_overflow | output | 1 | Open refused, stack full |
| err_underflow | output | 1 | Alternate or close refused, stack empty |

## Verification
The hardest state to reach from the ports is a completely full stack. It matters most when the mask has already gone to zero, because then every later push stores zeros. A lost or duplicated entry then stays hidden until the one non-zero entry at the bottom comes back out. The bench loads a zero compare, opens `DEPTH` regions, and tries one more. It then closes them one at a time. The mask must stay zero until the last close, and only that close may restore all lanes.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_OPEN    = 4'd1,
    OP_ALT     = 4'd2,
    OP_CLOSE   = 4'd3,
    OP_BRK     = 4'd4,
    OP_BRK_CMP = 4'd5,
    OP_BRK_SRC = 4'd6,
    OP_LOOP    = 4'd7
  } lmc_op_e;
endpackage

// File: rtl/lmc_mask_alu.sv
module lmc_mask_alu
  import lmc_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic [3:0]       op,
  input  logic [LANES-1:0] mask,
  input  logic [LANES-1:0] cmp,
  input  logic [LANES-1:0] brk,
  input  logic [LANES-1:0] top,
  input  logic [LANES-1:0] src,
  output logic [LANES-1:0] mask_nxt,
  output logic [LANES-1:0] brk_nxt,
  output logic [LANES-1:0] res_nxt,
  output logic             legal,
  output logic             push,
  output logic             pop,
  output logic             repl,
  output logic             loop_hit
);
  logic [LANES-1:0] merged;
  logic [LANES-1:0] trimmed;

  assign merged  = mask | top;
  assign trimmed = mask & ~brk;

  always_comb begin
    mask_nxt = mask;
    brk_nxt  = brk;
    res_nxt  = '0;
    legal    = 1'b1;
    push     = 1'b0;
    pop      = 1'b0;
    repl     = 1'b0;
    loop_hit = 1'b0;
    case (op)
      OP_OPEN: begin
        mask_nxt = mask & cmp;
        res_nxt  = (mask & cmp) ^ mask;
        push     = 1'b1;
      end
      OP_ALT: begin
        mask_nxt = merged ^ mask;
        res_nxt  = mask;
        repl     = 1'b1;
      end
      OP_CLOSE: begin
        mask_nxt = merged;
        res_nxt  = merged;
        pop      = 1'b1;
      end
      OP_BRK: begin
        brk_nxt = brk | mask;
        res_nxt = brk | mask;
      end
      OP_BRK_CMP: begin
        brk_nxt = brk | cmp;
        res_nxt = brk | cmp;
      end
      OP_BRK_SRC: begin
        brk_nxt = brk | src;
        res_nxt = brk | src;
      end
      OP_LOOP: begin
        mask_nxt = trimmed;
        res_nxt  = trimmed;
        loop_hit = |trimmed;
        brk_nxt  = (|trimmed) ? brk : '0;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lmc_save_stack.sv
module lmc_save_stack #(
  parameter int W     = 64,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         repl,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic [W-1:0]  slot_bus [DEPTH];

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    cnt_en = push | pop;
    cnt_d  = cnt_q;
    if (push)     cnt_d = cnt_q + CW'(1);
    else if (pop) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         slot_en;
    assign slot_en = (push && cnt_q == CW'(i)) || (repl && cnt_q == CW'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= din;
    end
    assign slot_bus[i] = slot_q;
  end

  always_comb begin
    top = '0;
    for (int k = 0; k < DEPTH; k++)
      if (cnt_q == CW'(k + 1)) top = slot_bus[k];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || repl) |-> !empty); // R10
  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !empty); // R12
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lmc_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             busy,
  input  logic [3:0]       op_code,
  input  logic [LANES-1:0] src_mask,
  input  logic             cmp_we,
  input  logic [LANES-1:0] cmp_data,
  output logic [LANES-1:0] lane_mask,
  output logic [LANES-1:0] brk_mask,
  output logic [LANES-1:0] res_mask,
  output logic             lanes_off,
  output logic             lanes_on,
  output logic             loop_again,
  output logic             err_overflow,
  output logic             err_underflow
);
  logic [LANES-1:0] mask_q, brk_q, cmp_q, res_q;
  logic [LANES-1:0] mask_nxt, brk_nxt, res_nxt, stk_top;
  logic             loop_q, ovf_q, unf_q;
  logic             alu_legal, alu_push, alu_pop, alu_repl, alu_loop;
  logic             stk_full, stk_empty;
  logic             accept, ovf_d, unf_d, go;

  lmc_mask_alu #(.LANES(LANES)) u_alu (
    .op       (op_code),
    .mask     (mask_q),
    .cmp      (cmp_q),
    .brk      (brk_q),
    .top      (stk_top),
    .src      (src_mask),
    .mask_nxt (mask_nxt),
    .brk_nxt  (brk_nxt),
    .res_nxt  (res_nxt),
    .legal    (alu_legal),
    .push     (alu_push),
    .pop      (alu_pop),
    .repl     (alu_repl),
    .loop_hit (alu_loop)
  );

  lmc_save_stack #(.W(LANES), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (go & alu_push),
    .pop   (go & alu_pop),
    .repl  (go & alu_repl),
    .din   (res_nxt),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_comb begin
    accept = op_valid & ~busy & alu_legal;
    ovf_d  = accept & alu_push & stk_full;
    unf_d  = accept & (alu_pop | alu_repl) & stk_empty;
    go     = accept & ~ovf_d & ~unf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      brk_q  <= '0;
      res_q  <= '0;
    end else if (go) begin
      mask_q <= mask_nxt;
      brk_q  <= brk_nxt;
      res_q  <= res_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= cmp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      loop_q <= go & alu_loop;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  assign lane_mask     = mask_q;
  assign brk_mask      = brk_q;
  assign res_mask      = res_q;
  assign lanes_off     = ~|mask_q;
  assign lanes_on      = |mask_q;
  assign loop_again    = loop_q;
  assign err_overflow  = ovf_q;
  assign err_underflow = unf_q;

  AST_OPEN_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == OP_OPEN && !stk_full)
      |=> lane_mask == ($past(lane_mask) & $past(cmp_q))); // R3
  AST_CLOSE_WIDENS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == OP_CLOSE)
      |=> (($past(lane_mask) & ~lane_mask) == '0)); // R5
  AST_BREAK_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_BRK || op_code == OP_BRK_CMP || op_code == OP_BRK_SRC))
      |=> $stable(lane_mask)); // R7
  AST_LOOP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == OP_LOOP)
      |=> ((lane_mask & ~$past(lane_mask)) == '0)); // R8
  AST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || busy) |=> ($stable(lane_mask) && $stable(brk_mask) && $stable(res_mask))); // R11
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_overflow && err_underflow)); // R9
  AST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    lanes_on != lanes_off); // R6
endmodule

// File: tb/lane_mask_ctrl_tb.sv
module lane_mask_ctrl_tb;
  localparam int L = 64;
  localparam int D = 8;
  localparam logic [L-1:0] ONES = {L{1'b1}};
  localparam logic [L-1:0] LO   = 64'h0000_0000_FFFF_FFFF;
  localparam logic [L-1:0] HI   = 64'hFFFF_FFFF_0000_0000;

  typedef struct packed {
    logic         we;
    logic [L-1:0] cmp;
    logic [3:0]   op;
    logic [L-1:0] src;
    logic [L-1:0] e_mask;
    logic [L-1:0] e_brk;
    logic [L-1:0] e_res;
    logic         e_loop;
  } row_t;

  localparam int NR = 15;
  localparam row_t TBL [NR] = '{
    '{1'b1, LO, 4'd0, '0, ONES, '0, '0, 1'b0},
    '{1'b0, '0, 4'd1, '0, LO, '0, HI, 1'b0},
    '{1'b1, 64'h0F0F_0F0F_0F0F_0F0F, 4'd0, '0, LO, '0, HI, 1'b0},
    '{1'b0, '0, 4'd1, '0, 64'h0000_0000_0F0F_0F0F, '0, 64'h0000_0000_F0F0_F0F0, 1'b0},
    '{1'b0, '0, 4'd2, '0, 64'h0000_0000_F0F0_F0F0, '0, 64'h0000_0000_0F0F_0F0F, 1'b0},
    '{1'b0, '0, 4'd3, '0, LO, '0, LO, 1'b0},
    '{1'b0, '0, 4'd2, '0, HI, '0, LO, 1'b0},
    '{1'b0, '0, 4'd3, '0, ONES, '0, ONES, 1'b0},
    '{1'b1, 64'h0000_0000_0000_00FF, 4'd0, '0, ONES, '0, ONES, 1'b0},
    '{1'b0, '0, 4'd5, '0, ONES, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_00FF, 1'b0},
    '{1'b0, '0, 4'd7, '0, 64'hFFFF_FFFF_FFFF_FF00, 64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FF00, 1'b1},
    '{1'b0, '0, 4'd6, 64'hFFFF_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_0000_0000_00FF, 64'hFFFF_0000_0000_00FF, 1'b0},
    '{1'b0, '0, 4'd7, '0, 64'h0000_FFFF_FFFF_FF00, 64'hFFFF_0000_0000_00FF, 64'h0000_FFFF_FFFF_FF00, 1'b1},
    '{1'b0, '0, 4'd4, '0, 64'h0000_FFFF_FFFF_FF00, ONES, ONES, 1'b0},
    '{1'b0, '0, 4'd7, '0, '0, '0, '0, 1'b0}
  };

  logic clk, rst_n, op_valid, busy, cmp_we;
  logic [3:0] op_code;
  logic [L-1:0] src_mask, cmp_data;
  logic [L-1:0] lane_mask, brk_mask, res_mask;
  logic lanes_off, lanes_on, loop_again, err_overflow, err_underflow;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  lane_mask_ctrl #(.LANES(L), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .busy(busy),
    .op_code(op_code), .src_mask(src_mask), .cmp_we(cmp_we), .cmp_data(cmp_data),
    .lane_mask(lane_mask), .brk_mask(brk_mask), .res_mask(res_mask),
    .lanes_off(lanes_off), .lanes_on(lanes_on), .loop_again(loop_again),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [L-1:0] c, input logic [3:0] op,
                      input logic [L-1:0] s, input bit v, input bit b);
    cmp_we = we; cmp_data = c; op_code = op; src_mask = s; op_valid = v; busy = b;
    @(negedge clk);
    cmp_we = 1'b0; op_valid = 1'b0; busy = 1'b0; op_code = 4'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; busy = 1'b0; cmp_we = 1'b0;
    op_code = '0; src_mask = '0; cmp_data = '0;
    do_reset();
    chk("R1 mask", lane_mask, ONES);
    chk("R1 brk", brk_mask, '0);
    chk("R1 res", res_mask, '0);
    chk("R1 flags", {L{1'b0}} | {loop_again, err_overflow, err_underflow, lanes_off}, '0);

    for (int i = 0; i < NR; i++) begin
      step(TBL[i].we, TBL[i].cmp, TBL[i].op, TBL[i].src, 1'b1, 1'b0);
      chk($sformatf("R13 R3 R4 R5 mask row%0d", i), lane_mask, TBL[i].e_mask);
      chk($sformatf("R2 R7 brk row%0d", i), brk_mask, TBL[i].e_brk);
      chk($sformatf("R7 R8 res row%0d", i), res_mask, TBL[i].e_res);
      chk($sformatf("R8 loop row%0d", i), L'(loop_again), L'(TBL[i].e_loop));
      chk($sformatf("R6 flags row%0d", i), L'({lanes_off, lanes_on}),
          L'({TBL[i].e_mask == '0, TBL[i].e_mask != '0}));
    end
    @(negedge clk);
    chk("R8 loop pulse ends", L'(loop_again), '0);

    do_reset();
    chk("R1 mask after reset", lane_mask, ONES);
    step(1'b0, '0, 4'd1, '0, 1'b1, 1'b1);
    chk("R11 busy open", lane_mask, ONES);
    step(1'b0, '0, 4'd1, '0, 1'b0, 1'b0);
    chk("R11 not valid open", lane_mask, ONES);
    step(1'b0, '0, 4'd11, ONES, 1'b1, 1'b0);
    chk("R11 illegal opcode mask", lane_mask, ONES);
    chk("R11 illegal opcode res", res_mask, '0);
    step(1'b0, '0, 4'd6, ONES, 1'b1, 1'b1);
    chk("R11 busy break", brk_mask, '0);
    step(1'b0, '0, 4'd2, '0, 1'b1, 1'b0);
    chk("R10 alternate on empty", L'(err_underflow), L'(1));
    chk("R10 alternate no change", lane_mask, ONES);

    for (int i = 0; i < D; i++) step(1'b0, '0, 4'd1, '0, 1'b1, 1'b0);
    chk("R9 full no error", L'(err_overflow), '0);
    chk("R3 mask zero", lane_mask, '0);
    step(1'b0, '0, 4'd1, '0, 1'b1, 1'b0);
    chk("R9 overflow flag", L'(err_overflow), L'(1));
    @(negedge clk);
    chk("R9 overflow pulse ends", L'(err_overflow), '0);
    for (int i = 0; i < D - 1; i++) step(1'b0, '0, 4'd3, '0, 1'b1, 1'b0);
    chk("R12 inner closes keep zero", lane_mask, '0);
    step(1'b0, '0, 4'd3, '0, 1'b1, 1'b0);
    chk("R12 outer close restores", lane_mask, ONES);
    step(1'b0, '0, 4'd3, '0, 1'b1, 1'b0);
    chk("R10 close on empty", L'(err_underflow), L'(1));
    chk("R10 close no change", lane_mask, ONES);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule